// File: doc/BRIEF.md
# Self-Timed Word Programming Sequencer

This block owns a 64-word by 16-bit nonvolatile-style storage array and carries out the programming commands that a serial front end decodes. Each command arrives as a single-cycle strobe that carries a 3-bit operation code, a 6-bit word address and a 16-bit data word. The front end does the bit shifting. The sequencer decides whether the command may run, and then times it with a cycle counter. At the end of the timed interval it commits the result to the array.

Programming is guarded by an enable latch. The latch comes out of reset cleared and changes only through two dedicated commands. A write always lands as exact data, because the old word is erased implicitly first. A write-all clears the whole array before it fills every word. Each kind of operation has its own duration in milliseconds. A clock-rate parameter, given in kHz, converts these durations to cycles. While an operation runs, `busy` is high, new commands are dropped, and reads return the old contents. A one-cycle `done` pulse marks the end. Reads use a separate combinational port and never depend on the enable latch.

Top module: `word_prog_seq`

## Requirements
- R1: After reset `busy` and `done` are low, every word reads 16'hFFFF and programming is disabled.
- R2: While programming is disabled, the codes 1 (erase word), 2 (erase all), 3 (write word) and 4 (write all) are dropped. `busy` stays low and the array is unchanged.
- R3: Code 5 enables programming and code 6 disables it. The enable stays set until code 6 is accepted or reset is applied.
- R4: Erase word (code 1) leaves the addressed word at 16'hFFFF and no other word changes.
- R5: Erase all (code 2) leaves every word at 16'hFFFF.
- R6: Write word (code 3) leaves the addressed word equal to the supplied data, whatever it held before. No other word changes.
- R7: Write all (code 4) leaves every word equal to the supplied data.
- R8: An accepted program command raises `busy` in the cycle after the strobe. `busy` then stays high for exactly 2*CLK_KHZ cycles for codes 1 and 3, 6*CLK_KHZ cycles for code 2 and 15*CLK_KHZ cycles for code 4.
- R9: Every strobe that arrives while `busy` is high is dropped, enable and disable included. Codes 0 and 7 are dropped at any time.
- R10: `rd_data` shows the word at `rd_addr` combinationally and does not depend on the enable state. The array changes only on the last `busy` cycle, so a read while `busy` is high returns the old value.
- R11: `done` is high for exactly one cycle: the first cycle in which `busy` is low after a timed operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 6 | Target word address |
| cmd_data | input | 16 | Data for write word and write all |
| rd_addr | input | 6 | Read address |
| rd_data | output | 16 | Word at rd_addr |
| busy | output | 1 | Timed operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The assertions assume that `cmd_valid` is a strobe whose fields are valid whenever it is high. They also assume that reset is applied before the first command. Nothing is assumed about the timing of strobes relative to `busy`. To exercise the drop path, the stimulus deliberately places strobes inside busy windows. It drives inputs only on falling edges and holds each strobe for exactly one rising edge. Random operation codes cover the whole 3-bit range, reserved values included, and random addresses and data cover the full width.

// File: rtl/word_prog_pkg.sv
package word_prog_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_ERASE = 3'd1,
        OP_ERALL = 3'd2,
        OP_WRITE = 3'd3,
        OP_WRALL = 3'd4,
        OP_ARM   = 3'd5,
        OP_DISARM= 3'd6,
        OP_RSVD  = 3'd7
    } prog_op_e;

    typedef struct packed {
        prog_op_e            op;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
    } prog_job_t;

    function automatic logic is_timed(prog_op_e op);
        return (op == OP_ERASE) || (op == OP_ERALL) ||
               (op == OP_WRITE) || (op == OP_WRALL);
    endfunction

    function automatic int op_cycles(prog_op_e op, int clk_khz);
        case (op)
            OP_ERALL: return 6 * clk_khz;
            OP_WRALL: return 15 * clk_khz;
            default:  return 2 * clk_khz;
        endcase
    endfunction

    function automatic int longest_cycles(int clk_khz);
        return 15 * clk_khz;
    endfunction

endpackage

// File: rtl/prog_cmd_ctrl.sv
module prog_cmd_ctrl
    import word_prog_pkg::*;
#(
    parameter int CLK_KHZ = 50000,
    parameter int CNT_W   = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [DATA_W-1:0]    cmd_data,
    input  logic                 busy,
    input  logic                 finish,
    output logic                 start,
    output logic [CNT_W-1:0]     load_val,
    output prog_job_t            job,
    output logic                 armed
);

    prog_op_e op_in;
    logic     take;

    assign op_in    = prog_op_e'(cmd_op);
    assign take     = cmd_valid && !busy;
    assign start    = take && armed && is_timed(op_in);
    assign load_val = CNT_W'(op_cycles(op_in, CLK_KHZ) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (take && op_in == OP_ARM) begin
            armed <= 1'b1;
        end else if (take && op_in == OP_DISARM) begin
            armed <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            job <= '{op: OP_IDLE, addr: '0, data: '0};
        end else if (start) begin
            job <= '{op: op_in, addr: cmd_addr, data: cmd_data};
        end
    end

    // R3: enable is dropped only by an accepted disable command
    a_r3_arm_holds: assert property (@(posedge clk) disable iff (rst)
        (armed && !(cmd_valid && !busy && cmd_op == 3'd6)) |=> armed);

    // R9: the captured job cannot change while an operation is timing
    a_r9_job_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && !finish) |=> $stable(job));

endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int CNT_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  load_val,
    output logic              busy,
    output logic              finish,
    output logic              done
);

    logic [CNT_W-1:0] remain;

    assign finish = busy && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (start && !busy) begin
                busy   <= 1'b1;
                remain <= load_val;
            end else if (busy) begin
                if (remain == '0) begin
                    busy <= 1'b0;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end

    // R8: an accepted start raises busy on the next cycle
    a_r8_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R11: done lasts one cycle and never overlaps busy
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: rtl/prog_array.sv
module prog_array
    import word_prog_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 apply,
    input  prog_job_t            job,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data
);

    logic [DEPTH-1:0][DATA_W-1:0] cells;
    logic [DEPTH-1:0]             row_hit;
    logic                         whole;
    logic [DATA_W-1:0]            fill;

    assign whole = (job.op == OP_ERALL) || (job.op == OP_WRALL);
    assign fill  = ((job.op == OP_WRITE) || (job.op == OP_WRALL)) ? job.data : '1;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
        assign row_hit[gi] = whole || (job.addr == ADDR_W'(gi));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cells <= '1;
        end else if (apply) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (row_hit[i]) begin
                    cells[i] <= fill;
                end
            end
        end
    end

    assign rd_data = cells[rd_addr];

    // R10: storage only moves on the final cycle of an operation
    a_r10_hold_until_apply: assert property (@(posedge clk) disable iff (rst)
        !apply |=> $stable(cells));

endmodule

// File: rtl/word_prog_seq.sv
module word_prog_seq
    import word_prog_pkg::*;
#(
    parameter int CLK_KHZ = 50000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [5:0]        cmd_addr,
    input  logic [15:0]       cmd_data,
    input  logic [5:0]        rd_addr,
    output logic [15:0]       rd_data,
    output logic              busy,
    output logic              done
);

    localparam int MAX_CYC = longest_cycles(CLK_KHZ);
    localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

    logic             start;
    logic             finish;
    logic             armed;
    logic [CNT_W-1:0] load_val;
    prog_job_t        job;

    prog_cmd_ctrl #(.CLK_KHZ(CLK_KHZ), .CNT_W(CNT_W)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .busy      (busy),
        .finish    (finish),
        .start     (start),
        .load_val  (load_val),
        .job       (job),
        .armed     (armed)
    );

    prog_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .load_val (load_val),
        .busy     (busy),
        .finish   (finish),
        .done     (done)
    );

    prog_array i_array (
        .clk     (clk),
        .rst     (rst),
        .apply   (finish),
        .job     (job),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // R2: a program code while disarmed and idle leaves busy low
    a_r2_disarmed_idle: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && !armed && cmd_op >= 3'd1 && cmd_op <= 3'd4) |=> !busy);

    // R9: a strobe during busy never restarts the timer
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && !finish) |=> busy);

endmodule

// File: tb/test_word_prog_seq.sv
module test_word_prog_seq;

    localparam int CLK_PERIOD = 10;
    localparam int KHZ        = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [5:0]  cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        busy;
    logic        done;

    int errors = 0;
    int checks = 0;

    logic [15:0] model [64];
    bit          arm_m;

    word_prog_seq #(.CLK_KHZ(KHZ)) i_word_prog_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_len(int op);
        if (op == 2) return 6 * KHZ;
        if (op == 4) return 15 * KHZ;
        return 2 * KHZ;
    endfunction

    function automatic bit is_prog(int op);
        return op >= 1 && op <= 4;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_word(int a, string tag);
        rd_addr = 6'(a);
        #1;
        chk(rd_data === model[a], tag, rd_data, model[a]);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        arm_m = 0;
    endtask

    task automatic apply_model(int op, int a, logic [15:0] d);
        case (op)
            1: model[a] = 16'hFFFF;
            2: for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
            3: model[a] = d;
            4: for (int i = 0; i < 64; i++) model[i] = d;
            default: ;
        endcase
    endtask

    // issue one command; optionally inject a strobe during busy
    task automatic run_cmd(int op, int a, logic [15:0] d, int inj);
        bit          acc = arm_m && is_prog(op);
        logic [15:0] old = model[a];
        int          n = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = 6'(a); cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (acc) begin
            chk(busy === 1'b1, "R8 busy rises after strobe", busy, 1);
            rd_addr = 6'(a);
            #1;
            chk(rd_data === old, "R10 read during busy is old", rd_data, old);
            while (busy === 1'b1 && n < 200) begin
                n++;
                if (n == 3 && inj != 0) begin
                    cmd_valid = 1'b1; cmd_op = 3'(inj); cmd_addr = 6'(a); cmd_data = ~d;
                end else begin
                    cmd_valid = 1'b0;
                end
                @(negedge clk);
            end
            cmd_valid = 1'b0;
            chk(n == exp_len(op), "R8 busy length", n, exp_len(op));
            chk(done === 1'b1, "R11 done after busy falls", done, 1);
            apply_model(op, a, d);
            case (op)
                1: chk_word(a, "R4 erase word");
                2: chk_word(a, "R5 erase all");
                3: chk_word(a, "R6 write word");
                default: chk_word(a, "R7 write all");
            endcase
            @(negedge clk);
            chk(done === 1'b0, "R11 done one cycle", done, 0);
            chk(busy === 1'b0, "R9 injected strobe dropped", busy, 0);
        end else begin
            chk(busy === 1'b0, "R2 R9 dropped command keeps idle", busy, 0);
            if (op == 5) arm_m = 1;
            if (op == 6) arm_m = 0;
            chk_word(a, "R2 dropped command leaves array");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0, "R1 busy after reset", busy, 0);
        chk(done === 1'b0, "R1 done after reset", done, 0);
        for (int i = 0; i < 64; i += 9) chk_word(i, "R1 erased after reset");

        // R2 disabled after reset
        run_cmd(3, 5, 16'h1234, 0);
        run_cmd(4, 0, 16'h0000, 0);
        // R3 enable then program
        run_cmd(5, 0, 0, 0);
        run_cmd(3, 5, 16'h1234, 0);
        run_cmd(3, 5, 16'h00F0, 1);           // R6 overwrite; R9 erase injected
        run_cmd(3, 6, 16'hBEEF, 6);           // R9 disable injected while busy
        run_cmd(3, 7, 16'h0F0F, 0);           // still armed
        chk_word(6, "R6 neighbour intact");
        run_cmd(1, 5, 0, 0);                  // R4
        chk_word(7, "R4 neighbour intact");
        run_cmd(0, 7, 16'h0, 0);              // R9 code 0
        run_cmd(7, 7, 16'h0, 0);              // R9 code 7
        run_cmd(4, 0, 16'hA5A5, 0);           // R7
        for (int i = 0; i < 64; i++) chk_word(i, "R7 all words");
        run_cmd(2, 3, 0, 0);                  // R5
        for (int i = 0; i < 64; i++) chk_word(i, "R5 all words");
        run_cmd(3, 9, 16'h5A5A, 0);
        run_cmd(6, 0, 0, 0);                  // R3 disable
        run_cmd(1, 9, 0, 0);
        run_cmd(2, 9, 0, 0);
        chk_word(9, "R3 R10 read while disabled");
        // R3 reset clears the enable
        run_cmd(5, 0, 0, 0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_reset();
        run_cmd(3, 2, 16'h7777, 0);
        chk_word(2, "R3 reset disarms");

        // random mix
        run_cmd(5, 0, 0, 0);
        for (int k = 0; k < 60; k++) begin
            int op = $urandom % 8;
            int a  = $urandom % 64;
            logic [15:0] d = 16'($urandom);
            if (op == 6 && ($urandom % 3) != 0) op = 3;
            run_cmd(op, a, d, 0);
            for (int j = 0; j < 3; j++) chk_word($urandom % 64, "R10 random read");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule